// File: doc/BRIEF.md
# Selectable Interrupt Source Latch

This block collects interrupt events for a data-acquisition front end and turns them into one interrupt request line. Four converter-side events compete for a single interrupt slot: an external interrupt pin, the end of a channel scan, the converter FIFO reaching half full, and the converter FIFO holding data. A two-bit select field picks one of them and a global converter enable lets it through. The output FIFO's half-full event has its own enable and is not affected by the select field.

Each event that gets through sets a sticky status bit on its rising edge, sampled in the system clock domain. Software reads the status word, which shows the five sticky bits next to the live converter FIFO flags. It clears any sticky bit by writing a one to the matching clear bit. Clear bits are pulses that only act during the write cycle, so software never has to write them back to zero. Every write also loads the select field and both enables.

Top module: `irq_source_latch`

## Requirements
- R1: After reset the select field is 0, both enables are 0, all five sticky bits are 0 and `irq_o` is 0.
- R2: Write word layout: bits [1:0] select, bit 2 converter enable, bit 3 output-FIFO enable, bits [8:4] clear bits in sticky-bit order. Select code 0 is the external pin, 1 end of scan, 2 converter FIFO half full, 3 converter FIFO not empty. When the converter enable is 1, a rising edge of the selected source sets its sticky bit (status bits 0 to 3 in code order) at the next clock edge.
- R3: A rising edge of a converter source that is not selected, or of any converter source while the converter enable is 0, sets no sticky bit.
- R4: With the output-FIFO enable at 1, a rising edge of `dac_half_i` sets status bit 4, whatever the select field and converter enable hold. With that enable at 0 it sets nothing.
- R5: A write with a clear bit at 1 clears that sticky bit at the write's clock edge. A clear bit at 0 leaves the bit unchanged. A clear does not persist: a later event sets the bit again without any rewrite.
- R6: If a set event and a clear of the same bit fall on the same clock edge, the bit ends up set.
- R7: Only rising edges set bits. A source held high after its bit is cleared does not set the bit again.
- R8: The not-empty sticky bit (bit 3) returns to 0 at the clock edge after `adc_ne_i` is seen low.
- R9: Status word layout: bits [4:0] sticky bits, bit 5 live `adc_ne_i`, bit 6 live `adc_full_i`. The live bits follow their inputs in the same cycle.
- R10: `irq_o` is 1 exactly when the sticky bit of the currently selected converter source is set while the converter enable is 1, or bit 4 is set while the output-FIFO enable is 1. It follows register state in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_ext_i | input | 1 | External interrupt source |
| ev_scan_i | input | 1 | End of channel scan event |
| adc_half_i | input | 1 | Converter FIFO half full flag |
| adc_ne_i | input | 1 | Converter FIFO not empty flag |
| adc_full_i | input | 1 | Converter FIFO full flag (status only) |
| dac_half_i | input | 1 | Output FIFO half full flag |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 9 | Write word (select, enables, clear bits) |
| status_o | output | 7 | Sticky bits and live FIFO flags |
| irq_o | output | 1 | Interrupt request |

## Verification
A source edge that is driven before a clock edge shows up in the sticky bits and `irq_o` right after that edge. A write also takes effect at the edge that samples the strobe. The bench drives every input on a falling edge and compares one falling edge later, so exactly one rising edge lies between stimulus and check. The live FIFO flags in the status word are combinational. They are checked a fraction of a nanosecond after the input changes, with no clock edge in between. The sweep covers every select code, both enable values and every source. The expected status and request are computed from the select code, the enable and the source index.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
  localparam int ADC_SRC_N  = 4;
  localparam int LAT_N      = ADC_SRC_N + 1;
  localparam int SEL_W      = $clog2(ADC_SRC_N);
  localparam int DAC_IDX    = ADC_SRC_N;
  localparam int NE_IDX     = 3;
  localparam int WR_SEL_LSB = 0;
  localparam int WR_AIEN    = SEL_W;
  localparam int WR_DIEN    = SEL_W + 1;
  localparam int WR_CLR_LSB = SEL_W + 2;
  localparam int WR_W       = WR_CLR_LSB + LAT_N;
  localparam int ST_LIVE_NE = LAT_N;
  localparam int ST_LIVE_FL = LAT_N + 1;
  localparam int ST_W       = LAT_N + 2;

  typedef enum logic [SEL_W-1:0] {
    SRC_EXT   = 2'd0,
    SRC_SCAN  = 2'd1,
    SRC_AHALF = 2'd2,
    SRC_ANE   = 2'd3
  } adc_src_e;

  typedef struct packed {
    logic     dac_ien;
    logic     adc_ien;
    adc_src_e sel;
  } irq_cfg_t;

  function automatic logic [ADC_SRC_N-1:0] sel_decode(input logic [SEL_W-1:0] s);
    logic [ADC_SRC_N-1:0] one;
    one = {{(ADC_SRC_N-1){1'b0}}, 1'b1};
    return one << s;
  endfunction

  function automatic logic irq_reduce(input logic [LAT_N-1:0] lat, input irq_cfg_t c);
    logic adc_part;
    adc_part = c.adc_ien & |(lat[ADC_SRC_N-1:0] & sel_decode(c.sel));
    return adc_part | (c.dac_ien & lat[DAC_IDX]);
  endfunction
endpackage

// File: rtl/irq_cfg_reg.sv
module irq_cfg_reg
  import irq_latch_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en_i,
  input  logic [WR_W-1:0]      wr_data_i,
  output irq_cfg_t             cfg_o,
  output logic [LAT_N-1:0]     clr_pulse_o
);
  irq_cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_en_i) begin
      cfg_q.sel     <= adc_src_e'(wr_data_i[WR_SEL_LSB +: SEL_W]);
      cfg_q.adc_ien <= wr_data_i[WR_AIEN];
      cfg_q.dac_ien <= wr_data_i[WR_DIEN];
    end
  end

  // clear bits act only in the write cycle, nothing is stored
  always_comb begin
    clr_pulse_o = '0;
    if (wr_en_i) clr_pulse_o = wr_data_i[WR_CLR_LSB +: LAT_N];
  end

  assign cfg_o = cfg_q;

  assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(cfg_q));
endmodule

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  for (genvar k = 0; k < N; k++) begin : g_edge
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[k] <= 1'b0;
      else        prev_q[k] <= src_i[k];
    end
    assign rise_o[k] = src_i[k] & ~prev_q[k];

    assert_no_double_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o[k] |=> !rise_o[k]);
  end
endmodule

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] drop_i,
  output logic [N-1:0] lat_o
);
  logic [N-1:0] lat_q;

  for (genvar k = 0; k < N; k++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        lat_q[k] <= 1'b0;
      else if (set_i[k]) lat_q[k] <= 1'b1;
      else if (clr_i[k] || drop_i[k]) lat_q[k] <= 1'b0;
    end

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[k] |=> lat_q[k]);
    assert_clear_acts_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i[k] && clr_i[k]) |=> !lat_q[k]);
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i[k] && !clr_i[k] && !drop_i[k]) |=> $stable(lat_q[k]));
  end

  assign lat_o = lat_q;
endmodule

// File: rtl/irq_source_latch.sv
module irq_source_latch
  import irq_latch_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_ext_i,
  input  logic              ev_scan_i,
  input  logic              adc_half_i,
  input  logic              adc_ne_i,
  input  logic              adc_full_i,
  input  logic              dac_half_i,
  input  logic              wr_en_i,
  input  logic [WR_W-1:0]   wr_data_i,
  output logic [ST_W-1:0]   status_o,
  output logic              irq_o
);
  irq_cfg_t             cfg;
  logic [LAT_N-1:0]     clr_pulse;
  logic [LAT_N-1:0]     src_vec;
  logic [LAT_N-1:0]     rise;
  logic [LAT_N-1:0]     set_vec;
  logic [LAT_N-1:0]     drop_vec;
  logic [LAT_N-1:0]     lat;
  logic [ADC_SRC_N-1:0] adc_gate;

  assign src_vec = {dac_half_i, adc_ne_i, adc_half_i, ev_scan_i, ev_ext_i};

  irq_cfg_reg u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .cfg_o       (cfg),
    .clr_pulse_o (clr_pulse)
  );

  irq_edge_detect #(.N(LAT_N)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_i  (src_vec),
    .rise_o (rise)
  );

  assign adc_gate = sel_decode(cfg.sel) & {ADC_SRC_N{cfg.adc_ien}};

  always_comb begin
    set_vec                     = '0;
    set_vec[ADC_SRC_N-1:0]      = rise[ADC_SRC_N-1:0] & adc_gate;
    set_vec[DAC_IDX]            = rise[DAC_IDX] & cfg.dac_ien;
    drop_vec                    = '0;
    drop_vec[NE_IDX]            = ~adc_ne_i;
  end

  irq_sticky_bank #(.N(LAT_N)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set_vec),
    .clr_i  (clr_pulse),
    .drop_i (drop_vec),
    .lat_o  (lat)
  );

  always_comb begin
    status_o             = '0;
    status_o[LAT_N-1:0]  = lat;
    status_o[ST_LIVE_NE] = adc_ne_i;
    status_o[ST_LIVE_FL] = adc_full_i;
  end

  assign irq_o = irq_reduce(lat, cfg);

  assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lat == '0) |-> !irq_o);
  assert_ne_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_ne_i |=> !lat[NE_IDX]);
  assert_adc_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.adc_ien |=> ((lat[ADC_SRC_N-1:0] & ~$past(lat[ADC_SRC_N-1:0])) == '0));
  assert_dac_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.dac_ien |=> !$rose(lat[DAC_IDX]));
endmodule

// File: tb/sim_irq_source_latch.sv
module sim_irq_source_latch;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_ext_i = 0, ev_scan_i = 0, adc_half_i = 0, adc_ne_i = 0;
  logic       adc_full_i = 0, dac_half_i = 0, wr_en_i = 0;
  logic [8:0] wr_data_i = '0;
  logic [6:0] status_o;
  logic       irq_o;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  irq_source_latch u0 (
    .clk(clk), .rst_n(rst_n), .ev_ext_i(ev_ext_i), .ev_scan_i(ev_scan_i),
    .adc_half_i(adc_half_i), .adc_ne_i(adc_ne_i), .adc_full_i(adc_full_i),
    .dac_half_i(dac_half_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .status_o(status_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] word(input int sel, input bit aien, input bit dien,
                                      input logic [4:0] clr);
    return {clr, dien, aien, sel[1:0]};
  endfunction

  task automatic wr(input int sel, input bit aien, input bit dien, input logic [4:0] clr);
    wr_en_i = 1; wr_data_i = word(sel, aien, dien, clr);
    @(negedge clk);
    wr_en_i = 0; wr_data_i = '0;
  endtask

  task automatic set_src(input int k, input logic v);
    case (k)
      0: ev_ext_i = v;
      1: ev_scan_i = v;
      2: adc_half_i = v;
      3: adc_ne_i = v;
      default: dac_half_i = v;
    endcase
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 status", status_o, 0);
    check("R1 irq", irq_o, 0);
    // R1: reset config: ext rising edge must not latch (enable 0)
    ev_ext_i = 1; @(negedge clk);
    check("R1 cfg enables off", status_o, 0);
    ev_ext_i = 0; @(negedge clk);

    // R2 R3 sweep: every select code, enable and converter source
    for (int sel = 0; sel < 4; sel++)
      for (int en = 0; en < 2; en++)
        for (int k = 0; k < 4; k++) begin
          int exp_lat;
          wr(sel, en[0], 0, 5'h1F);
          set_src(k, 1);
          @(negedge clk);
          exp_lat = (en == 1 && k == sel) ? (1 << k) : 0;
          check((exp_lat != 0) ? "R2 selected latch" : "R3 gated latch",
                status_o, exp_lat | ((k == 3) ? 32 : 0));
          check("R10 irq sweep", irq_o, (exp_lat != 0) ? 1 : 0);
          set_src(k, 0);
          @(negedge clk);
        end

    // R4 output FIFO half full, independent of select and converter enable
    wr(1, 0, 1, 5'h1F);
    dac_half_i = 1; @(negedge clk);
    check("R4 dac latch", status_o, 16);
    check("R4 dac irq", irq_o, 1);
    dac_half_i = 0;
    wr(1, 0, 0, 5'h1F);
    dac_half_i = 1; @(negedge clk);
    check("R4 dac disabled", status_o, 0);
    dac_half_i = 0; @(negedge clk);

    // R5 write zero no effect, write one clears, clear is a pulse
    wr(0, 1, 0, 5'h1F);
    ev_ext_i = 1; @(negedge clk); ev_ext_i = 0;
    wr(0, 1, 0, 5'h00);
    check("R5 zero clear keeps", status_o, 1);
    wr(0, 1, 0, 5'h01);
    check("R5 one clears", status_o, 0);
    ev_ext_i = 1; @(negedge clk); ev_ext_i = 0;
    check("R5 clear not stored", status_o, 1);

    // R10 mask by select, sticky bit kept
    wr(1, 1, 0, 5'h00);
    check("R10 deselected irq", irq_o, 0);
    check("R10 bit kept", status_o, 1);
    wr(0, 1, 0, 5'h00);
    check("R10 reselected irq", irq_o, 1);

    // R6 set and clear on the same edge
    wr(0, 1, 0, 5'h01);
    wr_en_i = 1; wr_data_i = word(0, 1, 0, 5'h01); ev_ext_i = 1;
    @(negedge clk);
    wr_en_i = 0; wr_data_i = '0;
    check("R6 set wins", status_o, 1);

    // R7 source held high after clear does not re-set
    wr(0, 1, 0, 5'h01);
    repeat (3) @(negedge clk);
    check("R7 level no retrigger", status_o, 0);
    ev_ext_i = 0; @(negedge clk);

    // R8 not-empty sticky bit drops when FIFO empties
    wr(3, 1, 0, 5'h1F);
    adc_ne_i = 1; @(negedge clk);
    check("R8 ne latched", status_o, 8 | 32);
    adc_ne_i = 0; #1;
    check("R9 live ne low", status_o, 8);
    @(negedge clk);
    check("R8 ne dropped", status_o, 0);
    check("R8 irq low", irq_o, 0);

    // R9 live full flag, combinational
    adc_full_i = 1; #1;
    check("R9 live full", status_o, 64);
    check("R9 full no irq", irq_o, 0);
    adc_full_i = 0; #1;
    check("R9 full low", status_o, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule